// File: doc/BRIEF.md
# Ultrasound Front-End SPI Configuration and Sample Readout Port

This block is an SPI slave that sits between a host processor and the control logic of a single-channel pulse-echo ultrasound front end. The host uses it to set the pulse timing, the acquisition window, the repetition period, the amplifier gain, the ADC rate code and a time-gain table. It also uses it to read back the samples that an acquisition engine has stored in a sample memory.

Every chip-select assertion carries exactly one 8-bit byte, and the slave samples MOSI on the rising edge of SCK. A register write takes three frames: a sync byte 0xAA, an address byte and a data byte. A frame whose byte is not 0xAA when a write is expected is a read request. While that frame runs, the block shifts out either a busy code or the next half of a packed sample. The block drives the memory read address and takes the stored word on `mem_rdata`: bits 11:10 hold a line ID and bits 9:0 hold the sample. The SPI pins are synchronised into `clk`, so SCK must stay well below a quarter of the clock rate.

Top module: `usnd_spi_ctrl`

## Requirements
- R1: After reset the outputs hold these values: pon_len=0x14, gap_len=0x0A, poff_len=0x00C8, acq_delay=0x02BC, acq_len=0x32C8, cycle_period=0x186A0, gain_level=0x11, adc_rate=0x03, every TGC byte 0x00, mem_addr=0, and both strobes low.
- R2: The frames 0xAA, A, D write D to register A. The register map is: 0xE0 pon_len; 0xD0 gap_len; 0xE1/0xE2 the high and low bytes of poff_len; 0xE3/0xE4 the high and low bytes of acq_delay; 0xE5/0xE6 the high and low bytes of acq_len; 0xE7/0xE8/0xE9 bits 23:16, 15:8 and 7:0 of cycle_period; 0xEC gain_level; 0xED adc_rate.
- R3: A frame that arrives while a sync byte is expected and whose byte is not 0xAA is a read request and changes no register output.
- R4: A write to an address outside 0xD0, 0xE0..0xEF and 0x10..0x38 changes no output.
- R5: The write address 0x10+k (k = 0..40) sets TGC byte k, which appears at tgc_flat[8k+7:8k].
- R6: Writing data with bit 0 set to 0xEA gives exactly one clock cycle of trig_pulse. The same write to 0xEF gives one clock cycle of memrst_pulse and returns mem_addr to 0. Data with bit 0 clear gives no pulse.
- R7: While acq_busy is high, a read frame returns 0xAA and the memory pointer does not move.
- R8: The first byte of a sample pair is {1, line ID, ext_in[1:0], sample[9:7]}. Bit 7 is 1, bits 6:5 hold the line ID, bits 4:3 hold ext_in and bits 2:0 hold the top three sample bits.
- R9: The second byte of a pair is {0, sample[6:0]}.
- R10: mem_addr increments by one after each completed pair of read bytes, and returns to 0 on a pulse of acq_start.
- R11: A frame that holds anything other than exactly 8 SCK rising edges is discarded and leaves the write sequence where it was.
- R12: Bit 0 of a write to 0xEB sets cont_mode (reset value 0). 0xEE sets cycle_count (reset value 0x0A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock (mode 0) |
| spi_cs_n | input | 1 | SPI chip select, active low, one byte per assertion |
| spi_mosi | input | 1 | Host to slave data, MSB first |
| spi_miso | output | 1 | Slave to host data, MSB first |
| acq_busy | input | 1 | Acquisition in progress |
| acq_start | input | 1 | One-cycle pulse when a new acquisition begins |
| ext_in | input | 2 | External input bits packed into the first readout byte |
| mem_addr | output | 19 | Sample memory read address |
| mem_rdata | input | 12 | Stored word: {line ID[1:0], sample[9:0]} |
| pon_len | output | 8 | Positive pulse length |
| gap_len | output | 8 | Gap between the positive and damping pulses |
| poff_len | output | 16 | Damping pulse length |
| acq_delay | output | 16 | Delay from damping to acquisition |
| acq_len | output | 16 | Acquisition length |
| cycle_period | output | 24 | Shot repetition period |
| cont_mode | output | 1 | 0 single shot, 1 continuous |
| cycle_count | output | 8 | Number of shots in continuous mode |
| gain_level | output | 8 | Gain control level |
| adc_rate | output | 8 | ADC rate code |
| tgc_flat | output | 328 | 41 time-gain bytes, entry k at bits 8k+7:8k |
| trig_pulse | output | 1 | One-cycle software trigger |
| memrst_pulse | output | 1 | One-cycle memory pointer reset |

## Verification
The bench goes after the frames that could be misclassified. A non-sync byte in the sync slot must leave every register unchanged; a design that treated it as an address would corrupt a register. A 7-bit frame in the data slot must be dropped; a design that counted it would write a shifted value, or would lose its place so that the next byte became a read. The bench also checks that the readout pointer moves only on a full pair and never during busy frames: a pointer that moves on every byte, or that keeps counting while busy, skips samples, and the byte scoreboard sees the wrong tag or the wrong sample. The last targets are the TGC table ends 0x10 and 0x38 and the unmapped neighbours 0x0F and 0x39, where an off-by-one decode writes a byte that should not exist.

// File: rtl/usnd_spi_pkg.sv
package usnd_spi_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'hAA;
    localparam logic [7:0] BUSY_BYTE = 8'hAA;
    localparam int         SAMPLE_W  = 10;
    localparam int         LINE_W    = 2;
    localparam int         WORD_W    = SAMPLE_W + LINE_W;
    localparam logic [7:0] TGC_BASE  = 8'h10;

    typedef enum logic [1:0] {P_SYNC, P_ADDR, P_DATA} proto_e;

    typedef struct packed {
        logic [7:0]  pon_len;
        logic [7:0]  gap_len;
        logic [15:0] poff_len;
        logic [15:0] acq_delay;
        logic [15:0] acq_len;
        logic [23:0] cycle_period;
        logic        cont_mode;
        logic [7:0]  cycle_count;
        logic [7:0]  gain_level;
        logic [7:0]  adc_rate;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        pon_len:      8'h14,
        gap_len:      8'h0A,
        poff_len:     16'h00C8,
        acq_delay:    16'h02BC,
        acq_len:      16'h32C8,
        cycle_period: 24'h0186A0,
        cont_mode:    1'b0,
        cycle_count:  8'h0A,
        gain_level:   8'h11,
        adc_rate:     8'h03
    };

    function automatic logic is_cfg_addr(input logic [7:0] a);
        return (a == 8'hD0) || (a[7:4] == 4'hE);
    endfunction

endpackage

// File: rtl/usnd_spi_rx.sv
module usnd_spi_rx (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       miso,
    output logic       frame_load,
    output logic       frame_done,
    output logic [7:0] rx_byte
);
    logic [2:0] sck_s, cs_s;
    logic [1:0] mosi_s;
    logic [3:0] bit_cnt;
    logic [7:0] tx_sh;

    wire sck_rise = sck_s[1] & ~sck_s[2];
    wire sck_fall = ~sck_s[1] & sck_s[2];
    wire cs_fall  = ~cs_s[1] & cs_s[2];
    wire cs_rise  = cs_s[1] & ~cs_s[2];
    wire active   = ~cs_s[1];

    assign frame_load = cs_fall;
    assign miso       = tx_sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_s      <= '0;
            cs_s       <= '1;
            mosi_s     <= '0;
            bit_cnt    <= '0;
            tx_sh      <= '0;
            rx_byte    <= '0;
            frame_done <= 1'b0;
        end else begin
            sck_s      <= {sck_s[1:0], sck};
            cs_s       <= {cs_s[1:0], cs_n};
            mosi_s     <= {mosi_s[0], mosi};
            frame_done <= 1'b0;
            if (cs_fall) begin
                tx_sh   <= tx_byte;
                bit_cnt <= '0;
            end else if (active) begin
                if (sck_rise) begin
                    rx_byte <= {rx_byte[6:0], mosi_s[1]};
                    if (bit_cnt != 4'd9) bit_cnt <= bit_cnt + 4'd1;
                end
                if (sck_fall) tx_sh <= {tx_sh[6:0], 1'b0};
            end else if (cs_rise && bit_cnt == 4'd8) begin
                frame_done <= 1'b1;
            end
        end
    end

    // R11: a completed frame must have seen exactly eight rising edges
    a_r11_eight_bits: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(bit_cnt) == 4'd8);

endmodule

// File: rtl/usnd_cfg_regs.sv
module usnd_cfg_regs
    import usnd_spi_pkg::*;
#(
    parameter int TGC_N = 41
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output cfg_t               cfg,
    output logic [TGC_N*8-1:0] tgc_flat,
    output logic               trig_pulse,
    output logic               memrst_pulse
);
    localparam int TGC_LAST = int'(TGC_BASE) + TGC_N - 1;

    logic hit_tgc;
    int   tgc_idx;

    always_comb begin
        hit_tgc = (int'(wr_addr) >= int'(TGC_BASE)) && (int'(wr_addr) <= TGC_LAST);
        tgc_idx = int'(wr_addr) - int'(TGC_BASE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg          <= CFG_RESET;
            tgc_flat     <= '0;
            trig_pulse   <= 1'b0;
            memrst_pulse <= 1'b0;
        end else begin
            trig_pulse   <= wr_en && wr_addr == 8'hEA && wr_data[0];
            memrst_pulse <= wr_en && wr_addr == 8'hEF && wr_data[0];
            if (wr_en && hit_tgc) tgc_flat[tgc_idx*8 +: 8] <= wr_data;
            if (wr_en) begin
                case (wr_addr)
                    8'hE0: cfg.pon_len              <= wr_data;
                    8'hD0: cfg.gap_len              <= wr_data;
                    8'hE1: cfg.poff_len[15:8]       <= wr_data;
                    8'hE2: cfg.poff_len[7:0]        <= wr_data;
                    8'hE3: cfg.acq_delay[15:8]      <= wr_data;
                    8'hE4: cfg.acq_delay[7:0]       <= wr_data;
                    8'hE5: cfg.acq_len[15:8]        <= wr_data;
                    8'hE6: cfg.acq_len[7:0]         <= wr_data;
                    8'hE7: cfg.cycle_period[23:16]  <= wr_data;
                    8'hE8: cfg.cycle_period[15:8]   <= wr_data;
                    8'hE9: cfg.cycle_period[7:0]    <= wr_data;
                    8'hEB: cfg.cont_mode            <= wr_data[0];
                    8'hEC: cfg.gain_level           <= wr_data;
                    8'hED: cfg.adc_rate             <= wr_data;
                    8'hEE: cfg.cycle_count          <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // R6: strobes clear themselves after one cycle
    a_r6_trig_single: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);
    a_r6_memrst_single: assert property (@(posedge clk) disable iff (rst)
        memrst_pulse |=> !memrst_pulse);
    // R4: unmapped writes leave the register file alone
    a_r4_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !hit_tgc && !is_cfg_addr(wr_addr)) |=> ($stable(cfg) && $stable(tgc_flat)));

endmodule

// File: rtl/usnd_readout.sv
module usnd_readout
    import usnd_spi_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              ack,
    input  logic              clr,
    input  logic              busy,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [1:0]        ext_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        tx_byte
);
    logic half;
    logic was_data;
    logic [SAMPLE_W-1:0] smp;
    logic [LINE_W-1:0]   lid;

    always_comb begin
        smp = mem_rdata[SAMPLE_W-1:0];
        lid = mem_rdata[WORD_W-1:SAMPLE_W];
        if (busy)      tx_byte = BUSY_BYTE;
        else if (half) tx_byte = {1'b0, smp[6:0]};
        else           tx_byte = {1'b1, lid, ext_in, smp[9:7]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            half     <= 1'b0;
            was_data <= 1'b0;
        end else if (clr) begin
            mem_addr <= '0;
            half     <= 1'b0;
        end else begin
            if (load) was_data <= !busy;
            if (ack && was_data) begin
                half <= !half;
                if (half) mem_addr <= mem_addr + 1'b1;
            end
        end
    end

    // R10: the pointer only ever steps by one unless cleared
    a_r10_ptr_step: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mem_addr) && !$past(clr)) |-> mem_addr == $past(mem_addr) + 1'b1);
    // R6/R10: a clear returns the pointer to zero
    a_r10_clr_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> mem_addr == '0);
    // R7: a busy frame never moves the pointer
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (ack && !was_data && !clr) |=> $stable(mem_addr));

endmodule

// File: rtl/usnd_spi_ctrl.sv
module usnd_spi_ctrl
    import usnd_spi_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int TGC_N  = 41
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               spi_sck,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    input  logic               acq_busy,
    input  logic               acq_start,
    input  logic [1:0]         ext_in,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [11:0]        mem_rdata,
    output logic [7:0]         pon_len,
    output logic [7:0]         gap_len,
    output logic [15:0]        poff_len,
    output logic [15:0]        acq_delay,
    output logic [15:0]        acq_len,
    output logic [23:0]        cycle_period,
    output logic               cont_mode,
    output logic [7:0]         cycle_count,
    output logic [7:0]         gain_level,
    output logic [7:0]         adc_rate,
    output logic [TGC_N*8-1:0] tgc_flat,
    output logic               trig_pulse,
    output logic               memrst_pulse
);
    logic       frame_load, frame_done;
    logic [7:0] rx_byte, tx_byte, addr_q;
    proto_e     pst;
    logic       wr_en, read_ack;
    cfg_t       cfg;

    usnd_spi_rx u_rx (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .tx_byte(tx_byte), .miso(spi_miso), .frame_load(frame_load),
        .frame_done(frame_done), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pst      <= P_SYNC;
            addr_q   <= '0;
            wr_en    <= 1'b0;
            read_ack <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            read_ack <= 1'b0;
            if (frame_done) begin
                case (pst)
                    P_SYNC: if (rx_byte == SYNC_BYTE) pst <= P_ADDR;
                            else read_ack <= 1'b1;
                    P_ADDR: begin addr_q <= rx_byte; pst <= P_DATA; end
                    default: begin wr_en <= 1'b1; pst <= P_SYNC; end
                endcase
            end
        end
    end

    usnd_cfg_regs #(.TGC_N(TGC_N)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr_q), .wr_data(rx_byte),
        .cfg(cfg), .tgc_flat(tgc_flat), .trig_pulse(trig_pulse),
        .memrst_pulse(memrst_pulse)
    );

    usnd_readout #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst), .load(frame_load), .ack(read_ack),
        .clr(memrst_pulse | acq_start), .busy(acq_busy), .mem_rdata(mem_rdata),
        .ext_in(ext_in), .mem_addr(mem_addr), .tx_byte(tx_byte)
    );

    assign pon_len      = cfg.pon_len;
    assign gap_len      = cfg.gap_len;
    assign poff_len     = cfg.poff_len;
    assign acq_delay    = cfg.acq_delay;
    assign acq_len      = cfg.acq_len;
    assign cycle_period = cfg.cycle_period;
    assign cont_mode    = cfg.cont_mode;
    assign cycle_count  = cfg.cycle_count;
    assign gain_level   = cfg.gain_level;
    assign adc_rate     = cfg.adc_rate;

    // R3: a read request in the sync slot leaves registers untouched
    a_r3_read_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
        (frame_done && pst == P_SYNC && rx_byte != SYNC_BYTE) |=> ##1 ($stable(cfg) && $stable(tgc_flat)));
    // R2: a register write only ever closes a three-frame sequence
    a_r2_write_ends_seq: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (pst == P_SYNC && $past(pst) == P_DATA));

endmodule

// File: tb/usnd_spi_ctrl_bench.sv
module usnd_spi_ctrl_bench;
    logic clk = 1'b0, rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso;
    logic acq_busy = 1'b0, acq_start = 1'b0;
    logic [1:0] ext_in = 2'b10;
    logic [18:0] mem_addr;
    logic [11:0] mem_rdata;
    logic [7:0] pon_len, gap_len, gain_level, adc_rate, cycle_count;
    logic [15:0] poff_len, acq_delay, acq_len;
    logic [23:0] cycle_period;
    logic cont_mode, trig_pulse, memrst_pulse;
    logic [327:0] tgc_flat;

    int checks = 0, failures = 0, trig_cnt = 0, mrst_cnt = 0;
    int exp_ptr = 0, exp_half = 0;
    bit done = 0;
    logic [7:0] exp_q[$], got_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    assign mem_rdata = {mem_addr[3:2], 10'(mem_addr * 19'd37 + 19'd5)};

    usnd_spi_ctrl u_usnd_spi_ctrl (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .acq_busy(acq_busy), .acq_start(acq_start), .ext_in(ext_in),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pon_len(pon_len), .gap_len(gap_len),
        .poff_len(poff_len), .acq_delay(acq_delay), .acq_len(acq_len),
        .cycle_period(cycle_period), .cont_mode(cont_mode), .cycle_count(cycle_count),
        .gain_level(gain_level), .adc_rate(adc_rate), .tgc_flat(tgc_flat),
        .trig_pulse(trig_pulse), .memrst_pulse(memrst_pulse)
    );

    always @(negedge clk) begin
        if (trig_pulse)   trig_cnt++;
        if (memrst_pulse) mrst_cnt++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] snap();
        return {pon_len, gap_len, poff_len, acq_delay, acq_len, cycle_period,
                cont_mode, cycle_count, gain_level, adc_rate, tgc_flat};
    endfunction

    task automatic frame(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = b[7-i];
            repeat (8) @(negedge clk);
            r[7-i] = miso;
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r;
        frame(8'hAA, 8, r); frame(a, 8, r); frame(d, 8, r);
    endtask

    // driver: push the expected byte, run the frame, hand the result to the monitor
    task automatic rd(input string req, input logic [7:0] dummy);
        logic [7:0] r, e;
        logic [9:0] s;
        logic [18:0] a;
        a = 19'(exp_ptr);
        s = 10'(a * 19'd37 + 19'd5);
        if (acq_busy) e = 8'hAA;
        else if (exp_half == 1) e = {1'b0, s[6:0]};
        else e = {1'b1, a[3:2], ext_in, s[9:7]};
        exp_q.push_back(e); tag_q.push_back(req);
        frame(dummy, 8, r);
        got_q.push_back(r);
        if (!acq_busy) begin
            if (exp_half == 1) exp_ptr++;
            exp_half = 1 - exp_half;
        end
    endtask

    // monitor: compare each returned byte against the scoreboard
    initial begin
        forever begin
            wait (got_q.size() > 0);
            check(tag_q.pop_front(), 32'(got_q.pop_front()), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [511:0] s0;
        logic [7:0] r;
        int tc;
        repeat (4) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset values
        check("R1 pon", 32'(pon_len), 32'h14);
        check("R1 gap", 32'(gap_len), 32'h0A);
        check("R1 poff", 32'(poff_len), 32'hC8);
        check("R1 delay", 32'(acq_delay), 32'h2BC);
        check("R1 acqlen", 32'(acq_len), 32'h32C8);
        check("R1 period", 32'(cycle_period), 32'h186A0);
        check("R1 gain", 32'(gain_level), 32'h11);
        check("R1 rate", 32'(adc_rate), 32'h03);
        check("R1 tgc", 32'(tgc_flat == '0), 32'h1);
        check("R1 addr", 32'(mem_addr), 32'h0);
        check("R12 mode", 32'(cont_mode), 32'h0);
        check("R12 count", 32'(cycle_count), 32'h0A);
        // R2 writes
        wr(8'hE0, 8'h25); check("R2 pon", 32'(pon_len), 32'h25);
        wr(8'hD0, 8'h3C); check("R2 gap", 32'(gap_len), 32'h3C);
        wr(8'hE1, 8'h12); wr(8'hE2, 8'h34); check("R2 poff", 32'(poff_len), 32'h1234);
        wr(8'hE7, 8'h01); wr(8'hE8, 8'h23); wr(8'hE9, 8'h45);
        check("R2 period", 32'(cycle_period), 32'h012345);
        wr(8'hED, 8'h07); check("R2 rate", 32'(adc_rate), 32'h07);
        // R12
        wr(8'hEB, 8'h01); check("R12 mode set", 32'(cont_mode), 32'h1);
        wr(8'hEE, 8'h05); check("R12 count set", 32'(cycle_count), 32'h05);
        // R5 TGC ends
        wr(8'h10, 8'h11); wr(8'h38, 8'h99);
        check("R5 tgc0", 32'(tgc_flat[7:0]), 32'h11);
        check("R5 tgc40", 32'(tgc_flat[327:320]), 32'h99);
        // R4 unmapped neighbours
        s0 = snap();
        wr(8'h0F, 8'h77); wr(8'h39, 8'h77); wr(8'hC0, 8'h77);
        check("R4 unmapped", 32'(snap() == s0), 32'h1);
        // R8 R9 R10 reads
        for (int i = 0; i < 6; i++) rd((i % 2 == 0) ? "R8 high byte" : "R9 low byte", 8'h00);
        check("R10 ptr after 3 pairs", 32'(mem_addr), 32'h3);
        // R3 non-sync read request
        s0 = snap();
        rd("R8 read request", 8'h5A);
        check("R3 regs kept", 32'(snap() == s0), 32'h1);
        check("R10 ptr mid pair", 32'(mem_addr), 32'h3);
        rd("R9 pair end", 8'h00);
        check("R10 ptr step", 32'(mem_addr), 32'h4);
        // R7 busy
        @(negedge clk); acq_busy = 1'b1;
        rd("R7 busy byte", 8'h00); rd("R7 busy byte", 8'h00); rd("R7 busy byte", 8'h00);
        check("R7 ptr held", 32'(mem_addr), 32'h4);
        @(negedge clk); acq_busy = 1'b0;
        rd("R8 after busy", 8'h00);
        // R6 memory reset
        tc = mrst_cnt;
        wr(8'hEF, 8'h01);
        exp_ptr = 0; exp_half = 0;
        check("R6 memrst one cycle", 32'(mrst_cnt - tc), 32'h1);
        check("R6 memrst addr", 32'(mem_addr), 32'h0);
        rd("R8 after memrst", 8'h00);
        rd("R9 after memrst", 8'h00);
        // R6 trigger
        tc = trig_cnt;
        wr(8'hEA, 8'h01);
        check("R6 trig one cycle", 32'(trig_cnt - tc), 32'h1);
        wr(8'hEA, 8'h00);
        check("R6 trig zero data", 32'(trig_cnt - tc), 32'h1);
        // R10 acq_start
        rd("R8 before start", 8'h00); rd("R9 before start", 8'h00);
        check("R10 ptr before start", 32'(mem_addr), 32'h2);
        @(negedge clk); acq_start = 1'b1; @(negedge clk); acq_start = 1'b0;
        exp_ptr = 0; exp_half = 0;
        @(negedge clk);
        check("R10 start clears", 32'(mem_addr), 32'h0);
        rd("R8 after start", 8'h00);
        rd("R9 after start", 8'h00);
        // R11 short frame in the data slot
        frame(8'hAA, 8, r); frame(8'hEC, 8, r); frame(8'h40, 7, r);
        check("R11 short frame dropped", 32'(gain_level), 32'h11);
        frame(8'h33, 8, r);
        check("R11 sequence kept", 32'(gain_level), 32'h33);
        check("R11 no read consumed", 32'(mem_addr), 32'h1);
        wait (got_q.size() == 0);
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule